// File: doc/BRIEF.md
# Eight-Channel Time-Division Serial Link

This block connects one device to a serial bus that several devices share. The bus has one data wire and one address wire. Time on the bus is cut into repeating frames of 128 bit times. Each frame holds eight channels, and each channel carries one 16-bit word. Every device owns one channel for sending. During that channel it puts its word on the data wire, most significant bit first. In the first eight bit times of the same channel it puts an 8-bit destination address on the address wire. A receive mask picks the channels this device listens to. An optional address filter further limits reception to words sent to this device's own address or to the broadcast address.

The host writes a word and its destination into a transmit holding register. The word moves to the shift register when the owned channel begins, and the holding register is then free for the next word. A received word stays in its output register until the next word is accepted. A mode input turns the port into a plain point-to-point link: every channel is then owned for sending and every word is taken on receive.

The frame machine has two states. FRM_HUNT leaves on a frame-sync pulse (HUNT→RUN). FRM_RUN holds for ever: a later sync pulse restarts the counter, and otherwise the counter wraps on its own. The transmit machine also has two states. TX_IDLE goes to TX_SEND when an owned channel starts with the holding register full. TX_SEND goes back to TX_IDLE at any channel start that does not load a word. TX_SEND stays in TX_SEND when an owned channel starts with the holding register full again.

Top module: `tdm_link`

## Requirements
- R1: Before the first `frm_sync` pulse the port neither drives nor receives. The clock after a pulse is bit 0 of channel 0. Channel c then covers bit times 16c to 16c+15, and the count wraps every 128 bit times with or without a further pulse.
- R2: In time-division mode `line_oe` is high exactly during the 16 bit times of channel `tx_slot` in which a word is sent. `dat_out` carries that word most significant bit first.
- R3: While `line_oe` is high, `adr_out` carries the destination address most significant bit first in bit times 0 to 7 of the channel, and 0 in bit times 8 to 15.
- R4: A `tx_wr` pulse stores `tx_word`/`tx_dest` in the holding register. A newer write replaces a word that has not been sent yet. The held word moves out when an owned channel starts, and `tx_int` pulses in that channel's bit 0.
- R5: If the holding register is empty when an owned channel starts, the lines stay released for that channel and `tx_urun` pulses in its bit 0.
- R6: The word seen in a channel whose `rx_mask` bit (bit c for channel c) is set is accepted. On acceptance `rx_word` and `rx_chan` update and `rx_int` pulses in the first bit time after the channel's last bit.
- R7: A word in a channel whose mask bit is clear gives no `rx_int` and leaves `rx_word` unchanged.
- R8: With `addr_filt` high, a masked channel is accepted only if the address from bit times 0 to 7 equals `local_addr` or is 8'hFF.
- R9: With `tdm_mode` low, every channel is an owned transmit channel, and every channel's word is accepted whatever the mask and filter.
- R10: During reset all outputs are 0 and the port is in FRM_HUNT with an empty holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| tdm_mode | input | 1 | 1 = time-division, 0 = point-to-point |
| tx_slot | input | 3 | Owned transmit channel |
| rx_mask | input | 8 | Receive channel mask, bit c = channel c |
| addr_filt | input | 1 | Enable destination-address filter |
| local_addr | input | 8 | This device's address |
| frm_sync | input | 1 | Frame sync pulse, one clock |
| tx_wr | input | 1 | Load transmit holding register |
| tx_word | input | 16 | Word to send |
| tx_dest | input | 8 | Destination address of the word |
| dat_in | input | 1 | Shared data wire as seen |
| adr_in | input | 1 | Shared address wire as seen |
| dat_out | output | 1 | Data wire drive value |
| adr_out | output | 1 | Address wire drive value |
| line_oe | output | 1 | Output enable for both wires |
| tx_int | output | 1 | Holding register emptied (pulse) |
| tx_urun | output | 1 | Owned channel started with nothing to send (pulse) |
| rx_word | output | 16 | Last accepted word |
| rx_chan | output | 3 | Channel of last accepted word |
| rx_int | output | 1 | Word accepted (pulse) |

## Verification
The bench steps the owned channel through all eight positions and gives each a differently shaped receive mask, so a shifted channel boundary or a wrong mask bit shows up as a mismatch. Other channels carry words and addresses that vary with frame and channel. The addresses cycle through own, broadcast and foreign values, which separates the three filter outcomes. Loads are placed before a frame, during it, twice in a row, or left out, which separates overwrite, carry-over to the next frame and underrun. A point-to-point pass with an empty mask and the filter on shows that the mode overrides both.

// File: rtl/tdm_link_pkg.sv
package tdm_link_pkg;
    typedef enum logic {FRM_HUNT, FRM_RUN} frm_state_e;
    typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;
endpackage

// File: rtl/tdm_frame_ctl.sv
module tdm_frame_ctl
    import tdm_link_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_sync,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic             nxt_valid,
    output logic [CNT_W-1:0] nxt_cnt
);
    frm_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FRM_HUNT: if (frm_sync) state_d = FRM_RUN;
            FRM_RUN:  state_d = FRM_RUN;
            default:  state_d = FRM_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FRM_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (nxt_valid) cnt_q <= nxt_cnt;
        end
    end

    always_comb begin
        running   = (state_q == FRM_RUN);
        nxt_valid = frm_sync || running;
        nxt_cnt   = frm_sync ? '0 : cnt_q + CNT_W'(1);
        cnt       = cnt_q;
    end
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
    import tdm_link_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8,
    parameter int CH_W   = 3,
    parameter int BIT_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tdm_mode,
    input  logic [CH_W-1:0]       own_slot,
    input  logic                  nxt_valid,
    input  logic [CH_W+BIT_W-1:0] nxt_cnt,
    input  logic                  wr,
    input  logic [WORD_W-1:0]     wr_word,
    input  logic [ADDR_W-1:0]     wr_dest,
    output logic                  dat_out,
    output logic                  adr_out,
    output logic                  oe,
    output logic                  tx_int,
    output logic                  tx_urun
);
    tx_state_e state_q, state_d;
    logic [WORD_W-1:0] hold_w, dsh;
    logic [ADDR_W-1:0] hold_a, ash;
    logic full;
    logic slot_start, own_start, load;

    assign slot_start = nxt_valid && (nxt_cnt[BIT_W-1:0] == '0);
    assign own_start  = slot_start &&
                        (!tdm_mode || (nxt_cnt[CH_W+BIT_W-1:BIT_W] == own_slot));
    assign load       = own_start && full;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (load) state_d = TX_SEND;
            TX_SEND: if (slot_start) state_d = load ? TX_SEND : TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            full    <= 1'b0;
            hold_w  <= '0;
            hold_a  <= '0;
            dsh     <= '0;
            ash     <= '0;
            tx_int  <= 1'b0;
            tx_urun <= 1'b0;
        end else begin
            state_q <= state_d;
            full    <= (full && !load) || wr;
            if (wr) begin
                hold_w <= wr_word;
                hold_a <= wr_dest;
            end
            if (load) begin
                dsh <= hold_w;
                ash <= hold_a;
            end else if (state_q == TX_SEND) begin
                dsh <= {dsh[WORD_W-2:0], 1'b0};
                ash <= {ash[ADDR_W-2:0], 1'b0};
            end
            tx_int  <= load;
            tx_urun <= own_start && !full;
        end
    end

    always_comb begin
        oe      = (state_q == TX_SEND);
        dat_out = oe && dsh[WORD_W-1];
        adr_out = oe && ash[ADDR_W-1];
    end
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx #(
    parameter int CH_NUM = 8,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8,
    parameter int CH_W   = 3,
    parameter int BIT_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  running,
    input  logic [CH_W+BIT_W-1:0] cnt,
    input  logic                  tdm_mode,
    input  logic [CH_NUM-1:0]     rx_mask,
    input  logic                  addr_filt,
    input  logic [ADDR_W-1:0]     local_addr,
    input  logic                  dat_in,
    input  logic                  adr_in,
    output logic [WORD_W-1:0]     rx_word,
    output logic [CH_W-1:0]       rx_chan,
    output logic                  rx_int
);
    logic [WORD_W-1:0] dsh;
    logic [ADDR_W-1:0] ash;
    logic [BIT_W-1:0]  bit_idx;
    logic [CH_W-1:0]   chan;
    logic word_end, addr_phase, addr_hit, accept;

    always_comb begin
        bit_idx    = cnt[BIT_W-1:0];
        chan       = cnt[CH_W+BIT_W-1:BIT_W];
        word_end   = running && (bit_idx == BIT_W'(WORD_W - 1));
        addr_phase = running && ({1'b0, bit_idx} < (BIT_W+1)'(ADDR_W));
        addr_hit   = (ash == local_addr) || (&ash);
        accept     = word_end &&
                     (!tdm_mode || (rx_mask[chan] && (!addr_filt || addr_hit)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dsh     <= '0;
            ash     <= '0;
            rx_word <= '0;
            rx_chan <= '0;
            rx_int  <= 1'b0;
        end else begin
            if (running)    dsh <= {dsh[WORD_W-2:0], dat_in};
            if (addr_phase) ash <= {ash[ADDR_W-2:0], adr_in};
            if (accept) begin
                rx_word <= {dsh[WORD_W-2:0], dat_in};
                rx_chan <= chan;
            end
            rx_int <= accept;
        end
    end
endmodule

// File: rtl/tdm_link.sv
module tdm_link #(
    parameter  int CH_NUM = 8,
    parameter  int WORD_W = 16,
    parameter  int ADDR_W = 8,
    localparam int CH_W   = $clog2(CH_NUM),
    localparam int BIT_W  = $clog2(WORD_W),
    localparam int CNT_W  = CH_W + BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tdm_mode,
    input  logic [CH_W-1:0]   tx_slot,
    input  logic [CH_NUM-1:0] rx_mask,
    input  logic              addr_filt,
    input  logic [ADDR_W-1:0] local_addr,
    input  logic              frm_sync,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [ADDR_W-1:0] tx_dest,
    input  logic              dat_in,
    input  logic              adr_in,
    output logic              dat_out,
    output logic              adr_out,
    output logic              line_oe,
    output logic              tx_int,
    output logic              tx_urun,
    output logic [WORD_W-1:0] rx_word,
    output logic [CH_W-1:0]   rx_chan,
    output logic              rx_int
);
    logic             running, nxt_valid;
    logic [CNT_W-1:0] cnt, nxt_cnt;

    tdm_frame_ctl #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .frm_sync(frm_sync),
        .running(running), .cnt(cnt), .nxt_valid(nxt_valid), .nxt_cnt(nxt_cnt)
    );

    tdm_tx #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CH_W(CH_W), .BIT_W(BIT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tdm_mode(tdm_mode), .own_slot(tx_slot),
        .nxt_valid(nxt_valid), .nxt_cnt(nxt_cnt),
        .wr(tx_wr), .wr_word(tx_word), .wr_dest(tx_dest),
        .dat_out(dat_out), .adr_out(adr_out), .oe(line_oe),
        .tx_int(tx_int), .tx_urun(tx_urun)
    );

    tdm_rx #(.CH_NUM(CH_NUM), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
             .CH_W(CH_W), .BIT_W(BIT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .running(running), .cnt(cnt),
        .tdm_mode(tdm_mode), .rx_mask(rx_mask), .addr_filt(addr_filt),
        .local_addr(local_addr), .dat_in(dat_in), .adr_in(adr_in),
        .rx_word(rx_word), .rx_chan(rx_chan), .rx_int(rx_int)
    );
endmodule

// File: rtl/tdm_link_chk.sv
module tdm_link_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              running,
    input logic              line_oe,
    input logic              tx_int,
    input logic              tx_urun,
    input logic              rx_int,
    input logic [WORD_W-1:0] rx_word
);
    AST_NO_DRIVE_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !line_oe); // R1
    AST_TXINT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_int |-> line_oe); // R4
    AST_URUN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_urun |-> !line_oe); // R5
    AST_TX_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_int && tx_urun)); // R5
    AST_RXINT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_int |=> !rx_int); // R6
    AST_RXWORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_int |-> $stable(rx_word)); // R7
endmodule

bind tdm_link tdm_link_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .line_oe(line_oe),
    .tx_int(tx_int), .tx_urun(tx_urun), .rx_int(rx_int), .rx_word(rx_word)
);

// File: tb/tdm_link_test.sv
module tdm_link_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tdm_mode = 1'b1;
    logic [2:0]  tx_slot = 3'd3;
    logic [7:0]  rx_mask = 8'hFF;
    logic        addr_filt = 1'b0;
    logic [7:0]  local_addr = 8'h5A;
    logic        frm_sync = 1'b0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_word = '0;
    logic [7:0]  tx_dest = '0;
    logic        ext_d = 1'b0, ext_a = 1'b0;
    logic        dat_in, adr_in, dat_out, adr_out, line_oe, tx_int, tx_urun, rx_int;
    logic [15:0] rx_word;
    logic [2:0]  rx_chan;

    int n_chk = 0, n_fail = 0, frame_no = 0;
    bit done = 0;
    bit b_full = 0, b_send = 0;
    logic [15:0] b_hold = '0, b_w = '0, exp_rx = '0;
    logic [7:0]  b_hold_a = '0, b_a = '0;
    logic [15:0] lw [8];
    logic [7:0]  la [8];

    always #10 clk = ~clk;

    assign dat_in = line_oe ? dat_out : ext_d;
    assign adr_in = line_oe ? adr_out : ext_a;

    tdm_link uut (
        .clk(clk), .rst_n(rst_n), .tdm_mode(tdm_mode), .tx_slot(tx_slot),
        .rx_mask(rx_mask), .addr_filt(addr_filt), .local_addr(local_addr),
        .frm_sync(frm_sync), .tx_wr(tx_wr), .tx_word(tx_word), .tx_dest(tx_dest),
        .dat_in(dat_in), .adr_in(adr_in), .dat_out(dat_out), .adr_out(adr_out),
        .line_oe(line_oe), .tx_int(tx_int), .tx_urun(tx_urun),
        .rx_word(rx_word), .rx_chan(rx_chan), .rx_int(rx_int)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ext_word(input int f, input int c);
        return 16'((f * 4951) ^ (c * 2457) ^ 16'hA5C3);
    endfunction

    function automatic logic [7:0] ext_addr(input int f, input int c);
        if (c % 3 == 0) return local_addr;
        if (c % 3 == 1) return 8'hFF;
        return (8'(c * 37 + f * 11) & 8'h7F) | 8'h01;
    endfunction

    // channel c begins: transmit side expectation (R4, R5, R9)
    task automatic slot_step(input int c);
        bit own;
        own = !tdm_mode || (c == int'(tx_slot));
        chk(tx_int === (own && b_full), "R4 tx_int at channel start", 32'(tx_int), 32'(own && b_full));
        chk(tx_urun === (own && !b_full), "R5 underrun at channel start", 32'(tx_urun), 32'(own && !b_full));
        if (own && b_full) begin
            b_send = 1; b_w = b_hold; b_a = b_hold_a; b_full = 0;
        end else begin
            b_send = 0;
        end
    endtask

    // channel c has ended: receive side expectation (R6, R7, R8, R9)
    task automatic rx_check(input int c);
        bit acc;
        string tag;
        acc = !tdm_mode || (rx_mask[c] && (!addr_filt || la[c] == local_addr || la[c] == 8'hFF));
        if (!tdm_mode)       tag = "R9 receive all";
        else if (!rx_mask[c]) tag = "R7 masked channel";
        else if (addr_filt)  tag = "R8 address filter";
        else                 tag = "R6 receive";
        if (acc) exp_rx = lw[c];
        chk(rx_int === acc, tag, 32'(rx_int), 32'(acc));
        chk(rx_word === exp_rx, tag, 32'(rx_word), 32'(exp_rx));
        if (acc) chk(rx_chan === 3'(c), "R6 channel number", 32'(rx_chan), 32'(c));
    endtask

    task automatic cycle_checks(input int i);
        int b;
        logic ea;
        b = i % 16;
        chk(line_oe === b_send, "R2 line enable", 32'(line_oe), 32'(b_send));
        if (b_send) begin
            chk(dat_out === b_w[15-b], "R2 data bit", 32'(dat_out), 32'(b_w[15-b]));
            ea = (b < 8) ? b_a[7-b] : 1'b0;
            chk(adr_out === ea, "R3 address bit", 32'(adr_out), 32'(ea));
        end
        if (b != 0) begin
            chk(tx_int === 1'b0 && tx_urun === 1'b0, "R4 no tx pulse mid-channel",
                32'({tx_int, tx_urun}), 32'(0));
            chk(rx_int === 1'b0, "R6 no rx pulse mid-channel", 32'(rx_int), 32'(0));
        end
    endtask

    task automatic run_frame(input bit ld1, input logic [15:0] w1, input logic [7:0] a1,
                             input bit ld2, input logic [15:0] w2, input logic [7:0] a2);
        for (int i = 0; i < 128; i++) begin
            int c, b;
            logic [15:0] ew;
            logic [7:0]  ea;
            c = i / 16; b = i % 16;
            if (b == 0 && i > 0) begin
                rx_check(c - 1);
                slot_step(c);
            end
            cycle_checks(i);
            ew = ext_word(frame_no, c);
            ea = ext_addr(frame_no, c);
            ext_d = ew[15-b];
            ext_a = (b < 8) ? ea[7-b] : 1'b0;
            if (b == 0) begin
                lw[c] = b_send ? b_w : ew;
                la[c] = b_send ? b_a : ea;
            end
            if (i == 0 && ld1) begin
                tx_wr = 1; tx_word = w1; tx_dest = a1;
                b_full = 1; b_hold = w1; b_hold_a = a1;
            end else if (i == 1 && ld2) begin
                tx_wr = 1; tx_word = w2; tx_dest = a2;
                b_full = 1; b_hold = w2; b_hold_a = a2;
            end else begin
                tx_wr = 0;
            end
            frm_sync = (i == 127);
            @(negedge clk);
        end
        frm_sync = 0;
        rx_check(7);
        slot_step(0);
        frame_no++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({dat_out, adr_out, line_oe, tx_int, tx_urun, rx_int} === 6'b0, "R10 reset outputs",
            32'({dat_out, adr_out, line_oe, tx_int, tx_urun, rx_int}), 32'(0));
        chk(rx_word === 16'h0 && rx_chan === 3'h0, "R10 reset rx regs", 32'(rx_word), 32'(0));
        rst_n = 1;
        // R1: nothing before sync, while the bus toggles and a word waits
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            ext_d = k[0]; ext_a = k[1];
            if (k == 5) begin
                tx_wr = 1; tx_word = 16'hC3A1; tx_dest = 8'h21;
                b_full = 1; b_hold = 16'hC3A1; b_hold_a = 8'h21;
            end else tx_wr = 0;
            chk(line_oe === 1'b0 && rx_int === 1'b0 && tx_urun === 1'b0, "R1 idle before sync",
                32'({line_oe, rx_int, tx_urun}), 32'(0));
        end
        @(negedge clk); frm_sync = 1;
        @(negedge clk); frm_sync = 0;
        slot_step(0);

        // preloaded word goes out in channel 3 (R2, R3, R4)
        run_frame(0, '0, '0, 0, '0, '0);
        // nothing loaded: underrun (R5); sparse mask (R7)
        rx_mask = 8'hA5;
        run_frame(0, '0, '0, 0, '0, '0);
        // filter: own address, broadcast and foreign (R8)
        rx_mask = 8'hFF; addr_filt = 1;
        run_frame(1, 16'h7E81, 8'h5A, 0, '0, '0);
        // overwrite before send: second word, broadcast dest (R4, R8)
        run_frame(1, 16'h1111, 8'h33, 1, 16'h9D2C, 8'hFF);
        // sweep owned channel and mask
        addr_filt = 0;
        for (int k = 1; k < 8; k++) begin
            tx_slot = 3'(k);
            rx_mask = 8'(1 << k) | 8'h01;
            run_frame(1, 16'(16'h0F0F ^ (k * 16'h1357)), 8'(k * 9), 0, '0, '0);
        end
        // channel 0: loaded too late for this frame, goes out in the next
        tx_slot = 3'd0; rx_mask = 8'h0F;
        run_frame(1, 16'hB00B, 8'h44, 0, '0, '0);
        run_frame(0, '0, '0, 0, '0, '0);
        // point-to-point: all channels own and received (R9)
        tdm_mode = 0; rx_mask = 8'h00; addr_filt = 1;
        run_frame(1, 16'h2222, 8'h10, 1, 16'h6A5F, 8'h11);
        run_frame(1, 16'hE4D1, 8'h12, 0, '0, '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule